// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small microcontroller through its power states. The core issues single-cycle register writes that request a mode. The controller decides whether each request is accepted. It then drives, from the current state, every enable that the clock, oscillator, regulator and power-net hardware needs: core and peripheral clock gates, two high-frequency oscillator enables, a regulator bias select, the LDO enable, the internal power-net enable, a pin-retention hold and a low-frequency timer clock enable.

There are six operating modes. Normal runs everything. Idle gates only the core and returns on any interrupt. Suspend and snooze stop all fast clocks and both fast oscillators, and differ only in regulator bias. Both wake on a chosen set of events and pass through an oscillator settle phase before the clocks return. Stop and shutdown share one request bit and are told apart by a stored configuration bit. Stop leaves only through a reset. Shutdown leaves only through the external reset pin or a power-on reset.

All enables are decoded from the registered state. Every transition therefore appears on the outputs one clock after the edge that causes it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low) the mode code is 0 (normal), and the enables are: core 1, peripheral 1, hfosc0 1, hfosc1 1, low bias 0, LDO 1, power net 1, hold 0, low-frequency timer 0.
- R2: Writing address 0 with bit 0 set enters idle (code 1): core 0, peripheral 1, all other enables as in normal. `irq_any` returns the controller to normal on the next cycle. Wake events have no effect in idle.
- R3: Writing address 1 with bit 0 set while `clk_on_hfosc0` is high enters suspend (code 2): core 0, peripheral 0, hfosc0 0, hfosc1 0, low bias 0, LDO 1, power net 1, hold 0, low-frequency timer 1.
- R4: A suspend or snooze write made while `clk_on_hfosc0` is low is dropped, and the mode stays normal.
- R5: Writing address 1 with bit 1 set (and `clk_on_hfosc0` high) enters snooze (code 3), with the same enables as suspend except low bias 1. If bits 0 and 1 are both set, suspend is entered.
- R6: In suspend or snooze, a high level on `wake_in[0]`..`wake_in[3]`, or a high-to-low transition on `wake_in[4]`, starts the wake. A rising edge on `wake_in[4]` and `irq_any` do not start it.
- R7: With the stop-config bit clear, writing address 0 with bit 1 set enters stop (code 4): all clocks and oscillators 0, low bias 0, LDO 1, power net 0, hold 1. Stop is left only when `pin_rst` or `sys_rst` is high, and the controller then goes to normal.
- R8: With the stop-config bit set (address 2, bit 0), the same write enters shutdown (code 5), with the stop enables except LDO 0. `sys_rst` is ignored there, and only `pin_rst` (or `por_n`) returns the controller to normal.
- R9: The hold output is high in stop and shutdown, and low in every other mode.
- R10: A wake moves the controller to settle (code 6) for exactly SETTLE_CYCLES cycles. In settle: hfosc0 1, hfosc1 0, core 0, peripheral 0, low bias 0, LDO 1, power net 1, timer 0. The controller then returns to normal.
- R11: Writes are acted on only in normal mode. A write to address 0 with both bits set enters stop or shutdown, not idle.
- R12: A reset that takes effect (`pin_rst`, or `sys_rst` outside shutdown) clears the stop-config bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst | input | 1 | External reset-pin request |
| sys_rst | input | 1 | Any other reset source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 mode A, 1 mode B, 2 regulator config |
| wr_data | input | DATA_W | Write data |
| clk_on_hfosc0 | input | 1 | System clock currently sourced from hfosc0 |
| irq_any | input | 1 | Any pending interrupt |
| wake_in | input | NUM_WAKE | Wake events: timer, SPI, I2C target, port match, comparator |
| mode | output | 3 | Current mode code |
| core_clk_en | output | 1 | Core clock gate |
| periph_clk_en | output | 1 | Peripheral clock gate |
| hfosc0_en | output | 1 | Primary fast oscillator enable |
| hfosc1_en | output | 1 | Secondary fast oscillator enable |
| reg_low_bias | output | 1 | Regulator low-bias select |
| ldo_en | output | 1 | Core LDO enable |
| pnet_en | output | 1 | Internal power-net enable |
| pin_hold | output | 1 | Pin-state retention |
| lf_tmr_en | output | 1 | Low-frequency clock to timers |

## Verification
The hardest state to reach from the ports is a comparator wake in suspend or snooze. It depends on the value the edge detector remembers, not on the present input, so the stimulus raises `wake_in[4]` while the controller is already asleep, checks that nothing happens, and then drops it. The stimulus sweeps every combination of clock-source flag, request kind and wake line. Each accepted entry is followed through every settle cycle, so the exact length of settle is checked on both sides.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [2:0] {
      PM_NORMAL   = 3'd0,
      PM_IDLE     = 3'd1,
      PM_SUSPEND  = 3'd2,
      PM_SNOOZE   = 3'd3,
      PM_STOP     = 3'd4,
      PM_SHUTDOWN = 3'd5,
      PM_SETTLE   = 3'd6
   } pm_state_e;

   typedef struct packed {
      logic idle;
      logic stop;
      logic suspend;
      logic snooze;
   } pm_req_t;

   typedef struct packed {
      logic core_clk;
      logic periph_clk;
      logic hfosc0;
      logic hfosc1;
      logic low_bias;
      logic ldo;
      logic pnet;
      logic hold;
      logic lf_tmr;
   } pm_ctl_t;
endpackage

// File: rtl/pmc_req_decode.sv
module pmc_req_decode
   import pmc_pkg::*;
#(
   parameter int ADDR_W     = 2,
   parameter int DATA_W     = 2,
   parameter int ADDR_A     = 0,
   parameter int ADDR_B     = 1,
   parameter int ADDR_CFG   = 2,
   parameter int IDLE_BIT   = 0,
   parameter int STOP_BIT   = 1,
   parameter int SUSP_BIT   = 0,
   parameter int SNOOZE_BIT = 1,
   parameter int CFG_BIT    = 0
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output pm_req_t           req,
   output logic              cfg_wr,
   output logic              cfg_val
);
   localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(ADDR_A);
   localparam logic [ADDR_W-1:0] B_SEL = ADDR_W'(ADDR_B);
   localparam logic [ADDR_W-1:0] C_SEL = ADDR_W'(ADDR_CFG);

   logic hit_a, hit_b;

   assign hit_a = wr_en && (wr_addr == A_SEL);
   assign hit_b = wr_en && (wr_addr == B_SEL);

   always_comb begin
      req         = '0;
      req.idle    = hit_a && wr_data[IDLE_BIT];
      req.stop    = hit_a && wr_data[STOP_BIT];
      req.suspend = hit_b && wr_data[SUSP_BIT];
      req.snooze  = hit_b && wr_data[SNOOZE_BIT];
   end

   assign cfg_wr  = wr_en && (wr_addr == C_SEL);
   assign cfg_val = wr_data[CFG_BIT];
endmodule

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
   parameter int                  NUM_WAKE  = 5,
   parameter logic [NUM_WAKE-1:0] FALL_MASK = '0
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic [NUM_WAKE-1:0] wake_in,
   output logic                wake_hit
);
   logic [NUM_WAKE-1:0] hit;

   for (genvar g = 0; g < NUM_WAKE; g++) begin : g_line
      if (FALL_MASK[g]) begin : g_fall
         logic prev;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) prev <= 1'b0;
            else        prev <= wake_in[g];
         end
         assign hit[g] = prev & ~wake_in[g];
      end else begin : g_level
         assign hit[g] = wake_in[g];
      end
   end

   assign wake_hit = |hit;
endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
   parameter int SETTLE_CYCLES = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic start,
   input  logic active,
   output logic done
);
   localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  cnt <= '0;
      else if (start)              cnt <= LOAD;
      else if (active && cnt != 0) cnt <= cnt - 1'b1;
   end

   assign done = active && (cnt == '0);
endmodule

// File: rtl/pmc_out_decode.sv
module pmc_out_decode
   import pmc_pkg::*;
(
   input  pm_state_e st,
   output pm_ctl_t   ctl
);
   always_comb begin
      ctl = '{core_clk:1'b1, periph_clk:1'b1, hfosc0:1'b1, hfosc1:1'b1,
              low_bias:1'b0, ldo:1'b1, pnet:1'b1, hold:1'b0, lf_tmr:1'b0};
      unique case (st)
         PM_NORMAL: ;
         PM_IDLE: ctl.core_clk = 1'b0;
         PM_SUSPEND, PM_SNOOZE: begin
            ctl.core_clk   = 1'b0;
            ctl.periph_clk = 1'b0;
            ctl.hfosc0     = 1'b0;
            ctl.hfosc1     = 1'b0;
            ctl.lf_tmr     = 1'b1;
            ctl.low_bias   = (st == PM_SNOOZE);
         end
         PM_SETTLE: begin
            ctl.core_clk   = 1'b0;
            ctl.periph_clk = 1'b0;
            ctl.hfosc1     = 1'b0;
         end
         PM_STOP, PM_SHUTDOWN: begin
            ctl.core_clk   = 1'b0;
            ctl.periph_clk = 1'b0;
            ctl.hfosc0     = 1'b0;
            ctl.hfosc1     = 1'b0;
            ctl.pnet       = 1'b0;
            ctl.hold       = 1'b1;
            ctl.ldo        = (st == PM_STOP);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int                  ADDR_W         = 2,
   parameter int                  DATA_W         = 2,
   parameter int                  SETTLE_CYCLES  = 8,
   parameter int                  NUM_WAKE       = 5,
   parameter logic [NUM_WAKE-1:0] WAKE_FALL_MASK = 5'b10000
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pin_rst,
   input  logic              sys_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clk_on_hfosc0,
   input  logic              irq_any,
   input  logic [NUM_WAKE-1:0] wake_in,
   output logic [2:0]        mode,
   output logic              core_clk_en,
   output logic              periph_clk_en,
   output logic              hfosc0_en,
   output logic              hfosc1_en,
   output logic              reg_low_bias,
   output logic              ldo_en,
   output logic              pnet_en,
   output logic              pin_hold,
   output logic              lf_tmr_en
);
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must hold both request bits");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must address three registers");
   end
   if (NUM_WAKE < 1) begin : g_bad_wake
      $error("NUM_WAKE must be at least 1");
   end

   pm_state_e st, nxt;
   pm_req_t   req;
   pm_ctl_t   ctl;
   logic      cfg_wr, cfg_val, stop_cfg, cfg_clr;
   logic      wake_hit, settle_done, settle_start, rst_take;

   pmc_req_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .req(req), .cfg_wr(cfg_wr), .cfg_val(cfg_val)
   );

   pmc_wake_detect #(.NUM_WAKE(NUM_WAKE), .FALL_MASK(WAKE_FALL_MASK)) u_wake (
      .clk(clk), .por_n(por_n), .wake_in(wake_in), .wake_hit(wake_hit)
   );

   pmc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk(clk), .por_n(por_n), .start(settle_start),
      .active(st == PM_SETTLE), .done(settle_done)
   );

   pmc_out_decode u_out (.st(st), .ctl(ctl));

   assign rst_take = pin_rst || (sys_rst && st != PM_SHUTDOWN);

   always_comb begin
      nxt     = st;
      cfg_clr = 1'b0;
      if (rst_take) begin
         nxt     = PM_NORMAL;
         cfg_clr = 1'b1;
      end else begin
         unique case (st)
            PM_NORMAL: begin
               if (req.stop)
                  nxt = stop_cfg ? PM_SHUTDOWN : PM_STOP;
               else if (req.idle)
                  nxt = PM_IDLE;
               else if ((req.suspend || req.snooze) && clk_on_hfosc0)
                  nxt = req.suspend ? PM_SUSPEND : PM_SNOOZE;
            end
            PM_IDLE:               if (irq_any) nxt = PM_NORMAL;
            PM_SUSPEND, PM_SNOOZE: if (wake_hit) nxt = PM_SETTLE;
            PM_SETTLE:             if (settle_done) nxt = PM_NORMAL;
            PM_STOP, PM_SHUTDOWN:  ;
            default:               nxt = PM_NORMAL;
         endcase
      end
   end

   assign settle_start = (nxt == PM_SETTLE) && (st != PM_SETTLE);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st       <= PM_NORMAL;
         stop_cfg <= 1'b0;
      end else begin
         st <= nxt;
         if (cfg_clr)
            stop_cfg <= 1'b0;
         else if (cfg_wr && st == PM_NORMAL)
            stop_cfg <= cfg_val;
      end
   end

   assign mode          = st;
   assign core_clk_en   = ctl.core_clk;
   assign periph_clk_en = ctl.periph_clk;
   assign hfosc0_en     = ctl.hfosc0;
   assign hfosc1_en     = ctl.hfosc1;
   assign reg_low_bias  = ctl.low_bias;
   assign ldo_en        = ctl.ldo;
   assign pnet_en       = ctl.pnet;
   assign pin_hold      = ctl.hold;
   assign lf_tmr_en     = ctl.lf_tmr;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
   input logic       clk,
   input logic       por_n,
   input logic       pin_rst,
   input logic       sys_rst,
   input logic       irq_any,
   input logic       clk_on_hfosc0,
   input logic [2:0] mode,
   input logic       core_clk_en,
   input logic       periph_clk_en,
   input logic       hfosc0_en,
   input logic       reg_low_bias,
   input logic       pnet_en,
   input logic       pin_hold,
   input logic       lf_tmr_en
);
   AST_IDLE_IRQ_RETURN: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd1 && irq_any) |=> (mode == 3'd0)); // R2

   AST_SLEEP_NEEDS_HF0: assert property (@(posedge clk) disable iff (!por_n)
      ((mode == 3'd2 || mode == 3'd3) && $past(mode) == 3'd0) |-> $past(clk_on_hfosc0)); // R4

   AST_LOW_BIAS_SLEEPING: assert property (@(posedge clk) disable iff (!por_n)
      reg_low_bias |-> (!core_clk_en && !periph_clk_en && lf_tmr_en)); // R5

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd4 && !pin_rst && !sys_rst) |=> (mode == 3'd4)); // R7

   AST_SHDN_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd5 && !pin_rst) |=> (mode == 3'd5)); // R8

   AST_NET_OFF_RETAINS: assert property (@(posedge clk) disable iff (!por_n)
      !pnet_en |-> pin_hold); // R9

   AST_OSC_BEFORE_CLK: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd0 && $past(mode) == 3'd6) |-> $past(hfosc0_en)); // R10
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
   .clk(clk), .por_n(por_n), .pin_rst(pin_rst), .sys_rst(sys_rst),
   .irq_any(irq_any), .clk_on_hfosc0(clk_on_hfosc0), .mode(mode),
   .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
   .hfosc0_en(hfosc0_en), .reg_low_bias(reg_low_bias), .pnet_en(pnet_en),
   .pin_hold(pin_hold), .lf_tmr_en(lf_tmr_en)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 4;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, pin_rst = 1'b0, sys_rst = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [1:0] wr_data = '0;
   logic       clk_on_hfosc0 = 1'b1, irq_any = 1'b0;
   logic [4:0] wake_in = '0;
   logic [2:0] mode;
   logic core_clk_en, periph_clk_en, hfosc0_en, hfosc1_en, reg_low_bias;
   logic ldo_en, pnet_en, pin_hold, lf_tmr_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
      .clk(clk), .por_n(por_n), .pin_rst(pin_rst), .sys_rst(sys_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .clk_on_hfosc0(clk_on_hfosc0), .irq_any(irq_any), .wake_in(wake_in),
      .mode(mode), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
      .hfosc0_en(hfosc0_en), .hfosc1_en(hfosc1_en), .reg_low_bias(reg_low_bias),
      .ldo_en(ldo_en), .pnet_en(pnet_en), .pin_hold(pin_hold), .lf_tmr_en(lf_tmr_en)
   );

   // Expected enables per mode code, ordered
   // core, periph, hf0, hf1, low bias, ldo, pnet, hold, lf timer.
   function automatic logic [8:0] exp_ctl(input logic [2:0] m);
      case (m)
         3'd0:    return 9'b1111_0110_0;
         3'd1:    return 9'b0111_0110_0;
         3'd2:    return 9'b0000_0110_1;
         3'd3:    return 9'b0000_1110_1;
         3'd4:    return 9'b0000_0101_0;
         3'd5:    return 9'b0000_0001_0;
         default: return 9'b0010_0110_0;
      endcase
   endfunction

   function automatic logic [8:0] act_ctl();
      return {core_clk_en, periph_clk_en, hfosc0_en, hfosc1_en, reg_low_bias,
              ldo_en, pnet_en, pin_hold, lf_tmr_en};
   endfunction

   task automatic chk_mode(input logic [2:0] exp, input string tag);
      checks++;
      if (mode !== exp) begin
         errors++;
         $display("FAIL %s mode actual %0d expected %0d", tag, mode, exp);
      end
   endtask

   task automatic chk_ctl(input logic [2:0] m, input string tag);
      checks++;
      if (act_ctl() !== exp_ctl(m)) begin
         errors++;
         $display("FAIL %s enables actual %b expected %b", tag, act_ctl(), exp_ctl(m));
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [1:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse_wake(input int line);
      wake_in[line] = 1'b1;
      step();
      wake_in[line] = 1'b0;
   endtask

   task automatic pulse_irq();
      irq_any = 1'b1; step(); irq_any = 1'b0;
   endtask

   task automatic pulse_sys();
      sys_rst = 1'b1; step(); sys_rst = 1'b0;
   endtask

   task automatic pulse_pin();
      pin_rst = 1'b1; step(); pin_rst = 1'b0;
   endtask

   // Start a wake on one line; the comparator line needs a high then low level.
   task automatic do_wake(input int line);
      if (line == 4) begin
         wake_in[4] = 1'b1;
         step();
         chk_mode(mode, "R6");
         wake_in[4] = 1'b0;
         step();
      end else begin
         pulse_wake(line);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [2:0] sleep_code;
      repeat (3) step();
      por_n = 1'b1;
      step();
      chk_mode(3'd0, "R1");
      chk_ctl(3'd0, "R1");

      // Idle entry, wake events ignored, interrupt return
      wr(2'd0, 2'b01);
      chk_mode(3'd1, "R2");
      chk_ctl(3'd1, "R2");
      for (int l = 0; l < 4; l++) begin
         pulse_wake(l);
         chk_mode(3'd1, "R2 wake ignored in idle");
      end
      wr(2'd0, 2'b10);
      chk_mode(3'd1, "R11 write ignored in idle");
      pulse_irq();
      chk_mode(3'd0, "R2 irq return");
      chk_ctl(3'd0, "R2");

      // Sweep: clock source x request kind x wake line
      for (int hf = 0; hf < 2; hf++) begin
         for (int kind = 0; kind < 3; kind++) begin
            for (int line = 0; line < 5; line++) begin
               clk_on_hfosc0 = hf[0];
               wr(2'd1, (kind == 0) ? 2'b01 : (kind == 1) ? 2'b10 : 2'b11);
               sleep_code = (hf == 0) ? 3'd0 : (kind == 1) ? 3'd3 : 3'd2;
               chk_mode(sleep_code, (hf == 0) ? "R4" : (kind == 1) ? "R5" : "R3");
               chk_ctl(sleep_code, (kind == 1) ? "R5" : "R3");
               if (hf != 0) begin
                  clk_on_hfosc0 = 1'b0;
                  pulse_irq();
                  chk_mode(sleep_code, "R6 irq ignored");
                  do_wake(line);
                  chk_mode(3'd6, "R6 wake line");
                  chk_ctl(3'd6, "R10");
                  for (int c = 1; c < SETTLE; c++) begin
                     step();
                     chk_mode(3'd6, "R10 still settling");
                  end
                  step();
                  chk_mode(3'd0, "R10 settle end");
                  chk_ctl(3'd0, "R10");
               end
            end
         end
      end
      clk_on_hfosc0 = 1'b1;

      // Comparator rising edge alone does not wake
      wr(2'd1, 2'b01);
      wake_in[4] = 1'b1;
      step();
      step();
      chk_mode(3'd2, "R6 rising edge ignored");
      wake_in[4] = 1'b0;
      step();
      chk_mode(3'd6, "R6 falling edge wakes");
      repeat (SETTLE) step();
      chk_mode(3'd0, "R10");

      // Stop: both bits in address 0 picks stop
      wr(2'd0, 2'b11);
      chk_mode(3'd4, "R11 stop over idle");
      chk_ctl(3'd4, "R7");
      checks++;
      if (pin_hold !== 1'b1) begin
         errors++; $display("FAIL R9 hold actual %b expected 1", pin_hold);
      end
      pulse_irq();
      pulse_wake(0);
      chk_mode(3'd4, "R7 no exit without reset");
      pulse_sys();
      chk_mode(3'd0, "R7 sys reset exit");
      checks++;
      if (pin_hold !== 1'b0) begin
         errors++; $display("FAIL R9 hold actual %b expected 0", pin_hold);
      end

      // Shutdown
      wr(2'd2, 2'b01);
      chk_mode(3'd0, "R8 config write keeps normal");
      wr(2'd0, 2'b10);
      chk_mode(3'd5, "R8");
      chk_ctl(3'd5, "R8");
      pulse_sys();
      chk_mode(3'd5, "R8 sys reset ignored");
      pulse_irq();
      chk_mode(3'd5, "R8");
      pulse_pin();
      chk_mode(3'd0, "R8 pin reset exit");

      // Config cleared by the reset
      wr(2'd0, 2'b10);
      chk_mode(3'd4, "R12 config cleared");
      pulse_pin();
      chk_mode(3'd0, "R7 pin reset exit");

      // Config explicitly cleared by write
      wr(2'd2, 2'b01);
      wr(2'd2, 2'b00);
      wr(2'd0, 2'b10);
      chk_mode(3'd4, "R7 config write clear");
      pulse_sys();
      chk_mode(3'd0, "R7");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule